// File: doc/BRIEF.md
# Tag Compare Unit with Gated Match Flag

This block turns a plain synchronous memory into a cache tag store. A compare request reads the stored word at the requested address through a simple read port. During that request the compare value is taken off the input bus into a held register, and the block reports a single flag saying whether the stored word and the held value agree on every bit. The block also serves ordinary reads. The data outputs are enabled only for ordinary reads and never for a compare, so the shared bus can carry the compare value instead.

A run-time mode input picks one of two timings, and the same choice applies to the match flag and to the read data. In flow-through mode the result appears in the cycle that follows the request edge. It is formed combinationally from the compare register and the word returned by the memory. In pipelined mode the result is registered once more and appears one cycle later. A separate enable, which acts without any clock, gates the match pin. Instead of a tri-state, the block reports whether that pin is driven through a flag of its own.

The memory behind the read port is external. It is sampled on the request edge (enable and address) and returns its word after that edge. It holds that word until the next read.

Top module: `tagcmp_match`

## Requirements
- R1: After reset, and until the first request is taken, matchValid, match, dataOutEn and dataOut are all 0.
- R2: A request (cmpReq or readReq) drives arrayRdEn high and arrayRdAddr equal to reqAddr in the same cycle.
- R3: A compare never enables the data outputs. While a compare result is shown, dataOutEn is 0 and dataOut is all zeros.
- R4: With ftMode=1, a compare sampled on edge N has matchValid=1 and its result on match between edge N and edge N+1.
- R5: With ftMode=0, a compare sampled on edge N has matchValid=1 and its result between edge N+1 and edge N+2. A read's data follows the same latency, with dataOutEn=1.
- R6: match is 1 only when all DATA_W bits of the stored word equal the compare value. A difference in any single bit gives 0.
- R7: matchDrive equals matchOutEn at all times, with no clock involved. While matchOutEn=0, match is 0 and matchValid is unaffected.
- R8: Compares issued back to back on consecutive edges, to different addresses, each produce their own result, in issue order, one per cycle, at the selected latency.
- R9: A compare does not change the memory contents. A later plain read of any address returns the word that was stored there.
- R10: When cmpReq and readReq are both high, the request is handled as a compare: matchValid=1 and dataOutEn=0 at the result slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ftMode | input | 1 | 1 = flow-through timing, 0 = pipelined timing |
| cmpReq | input | 1 | Compare request |
| readReq | input | 1 | Plain read request |
| reqAddr | input | ADDR_W | Address of the request |
| cmpData | input | DATA_W | Compare value from the input bus |
| matchOutEn | input | 1 | Asynchronous enable for the match pin |
| arrayRdEn | output | 1 | Read enable to the memory |
| arrayRdAddr | output | ADDR_W | Read address to the memory |
| arrayRdData | input | DATA_W | Word returned by the memory after the request edge |
| match | output | 1 | Match flag, gated by matchOutEn |
| matchDrive | output | 1 | 1 while the match pin counts as driven |
| matchValid | output | 1 | A compare result is shown this cycle |
| dataOutEn | output | 1 | Read data is shown this cycle |
| dataOut | output | DATA_W | Read data, zero while not enabled |

## Verification
Random streams mix compares, plain reads and idle cycles, back to back, in both timing modes. About half of the compare values equal the stored word, and the rest differ. These streams show whether each result lands in its own slot and in order at the right latency. A directed sweep flips one bit at a time across the word, which tells a full-width compare apart from a partial one. Toggling the match enable between clock edges separates asynchronous gating from a registered version. Simultaneous requests show that a compare wins over a read, and a closing read-back of every address shows that compares left the memory untouched.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadCmp;   // take compare value into the held register
    logic capMatch;  // register raw match for pipelined mode
    logic capData;   // register read data for pipelined mode
    logic ftSel;     // flow-through selection
    logic matchShow; // a compare result occupies the output slot
    logic dataShow;  // a read result occupies the output slot
  } cmpStrobes_t;
endpackage

// File: rtl/tagcmp_ctrl.sv
module tagcmp_ctrl
  import tagcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ftMode,
  input  logic        cmpReq,
  input  logic        readReq,
  output cmpStrobes_t strb,
  output logic        matchValid,
  output logic        dataOutEn
);
  logic s1Cmp, s1Rd, s2Cmp, s2Rd;
  logic takeRd;

  // compare wins when both are requested
  assign takeRd = readReq & ~cmpReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Cmp <= 1'b0;
      s1Rd  <= 1'b0;
      s2Cmp <= 1'b0;
      s2Rd  <= 1'b0;
    end else begin
      s1Cmp <= cmpReq;
      s1Rd  <= takeRd;
      s2Cmp <= s1Cmp;
      s2Rd  <= s1Rd;
    end
  end

  always_comb begin
    strb.loadCmp   = cmpReq;
    strb.capMatch  = s1Cmp;
    strb.capData   = s1Rd;
    strb.ftSel     = ftMode;
    strb.matchShow = ftMode ? s1Cmp : s2Cmp;
    strb.dataShow  = ftMode ? s1Rd  : s2Rd;
  end

  assign matchValid = strb.matchShow;
  assign dataOutEn  = strb.dataShow;

  // R3
  noDataOnCmp_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> !matchValid);

  // R10
  cmpWins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpReq && readReq) |=> (s1Cmp && !s1Rd));

endmodule

// File: rtl/tagcmp_dp.sv
module tagcmp_dp
  import tagcmp_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmpStrobes_t       strb,
  input  logic [DATA_W-1:0] cmpData,
  input  logic [DATA_W-1:0] arrayRdData,
  input  logic              matchOutEn,
  output logic              match,
  output logic              matchDrive,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] cmpDataQ;
  logic [DATA_W-1:0] dataQ;
  logic              matchQ;
  logic              rawMatch;
  logic              selMatch;
  logic [DATA_W-1:0] selData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpDataQ <= '0;
      dataQ    <= '0;
      matchQ   <= 1'b0;
    end else begin
      if (strb.loadCmp)  cmpDataQ <= cmpData;
      if (strb.capMatch) matchQ   <= rawMatch;
      if (strb.capData)  dataQ    <= arrayRdData;
    end
  end

  // full-width equality: reduction over the xor
  assign rawMatch = ~|(arrayRdData ^ cmpDataQ);

  assign selMatch   = strb.ftSel ? rawMatch : matchQ;
  assign selData    = strb.ftSel ? arrayRdData : dataQ;
  assign matchDrive = matchOutEn;
  assign match      = matchOutEn & strb.matchShow & selMatch;
  assign dataOut    = strb.dataShow ? selData : '0;

  // R7
  always_comb begin
    if (!matchDrive) begin
      undrivenLow_chk: assert (match == 1'b0);
    end
  end

  // R6
  pipeMismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capMatch && (arrayRdData != cmpDataQ)) |=> !matchQ);

endmodule

// File: rtl/tagcmp_match.sv
module tagcmp_match
  import tagcmp_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ftMode,
  input  logic              cmpReq,
  input  logic              readReq,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] cmpData,
  input  logic              matchOutEn,
  output logic              arrayRdEn,
  output logic [ADDR_W-1:0] arrayRdAddr,
  input  logic [DATA_W-1:0] arrayRdData,
  output logic              match,
  output logic              matchDrive,
  output logic              matchValid,
  output logic              dataOutEn,
  output logic [DATA_W-1:0] dataOut
);
  cmpStrobes_t strb;

  assign arrayRdEn   = cmpReq | readReq;
  assign arrayRdAddr = reqAddr;

  tagcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ftMode(ftMode), .cmpReq(cmpReq),
    .readReq(readReq), .strb(strb), .matchValid(matchValid),
    .dataOutEn(dataOutEn)
  );

  tagcmp_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpData(cmpData),
    .arrayRdData(arrayRdData), .matchOutEn(matchOutEn), .match(match),
    .matchDrive(matchDrive), .dataOut(dataOut)
  );

  // R4
  ftSlot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ftMode && $past(cmpReq)) |-> matchValid);

  // R5
  pipeSlot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ftMode && $past(cmpReq, 2)) |-> matchValid);

endmodule

// File: tb/tagcmp_match_bench.sv
module tagcmp_match_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int DW = 18;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ftMode = 1'b1, cmpReq = 1'b0, readReq = 1'b0, matchOutEn = 1'b1;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] cmpData = '0;
  logic arrayRdEn, match, matchDrive, matchValid, dataOutEn;
  logic [AW-1:0] arrayRdAddr;
  logic [DW-1:0] arrayRdData = '0;
  logic [DW-1:0] dataOut;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] golden [DEPTH];

  int errors = 0;
  int checks = 0;

  // expected entries: kind 0 idle, 1 compare, 2 read
  int histKind [2];
  logic histMatch [2];
  logic [DW-1:0] histData [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (arrayRdEn) arrayRdData <= mem[arrayRdAddr];

  tagcmp_match #(.ADDR_W(AW), .DATA_W(DW)) u_tagcmp_match (
    .clk(clk), .rstN(rstN), .ftMode(ftMode), .cmpReq(cmpReq),
    .readReq(readReq), .reqAddr(reqAddr), .cmpData(cmpData),
    .matchOutEn(matchOutEn), .arrayRdEn(arrayRdEn),
    .arrayRdAddr(arrayRdAddr), .arrayRdData(arrayRdData), .match(match),
    .matchDrive(matchDrive), .matchValid(matchValid),
    .dataOutEn(dataOutEn), .dataOut(dataOut)
  );

  task automatic chk(input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expMatchOf(input logic [DW-1:0] stored,
                                      input logic [DW-1:0] probe);
    return stored == probe;
  endfunction

  // check the slot due now, then drive the next request
  task automatic step(input int kind, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic en, input string tag);
    int idx;
    @(negedge clk);
    idx = ftMode ? 0 : 1;
    chk({tag, " matchValid"}, DW'(matchValid), DW'(histKind[idx] == 1));
    chk({tag, " match"}, DW'(match),
        DW'(matchOutEn && histKind[idx] == 1 && histMatch[idx]));
    chk("R3 dataOutEn", DW'(dataOutEn), DW'(histKind[idx] == 2));
    chk("R3 dataOut", dataOut, (histKind[idx] == 2) ? histData[idx] : '0);
    chk("R7 matchDrive", DW'(matchDrive), DW'(matchOutEn));
    cmpReq = (kind == 1) || (kind == 3);
    readReq = (kind == 2) || (kind == 3);
    reqAddr = a;
    cmpData = d;
    matchOutEn = en;
    #1;
    if (kind != 0) begin
      chk("R2 arrayRdEn", DW'(arrayRdEn), DW'(1));
      chk("R2 arrayRdAddr", DW'(arrayRdAddr), DW'(a));
    end
    histKind[1] = histKind[0];
    histMatch[1] = histMatch[0];
    histData[1] = histData[0];
    histKind[0] = (kind == 3) ? 1 : kind;
    histMatch[0] = expMatchOf(mem[a], d);
    histData[0] = mem[a];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, '0, matchOutEn, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'($urandom);
      golden[i] = mem[i];
    end
    for (int i = 0; i < 2; i++) begin
      histKind[i] = 0; histMatch[i] = 1'b0; histData[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 matchValid", DW'(matchValid), '0);
    chk("R1 match", DW'(match), '0);
    chk("R1 dataOutEn", DW'(dataOutEn), '0);
    chk("R1 dataOut", dataOut, '0);

    for (int m = 0; m < 2; m++) begin
      ftMode = (m == 0);
      idle(3);
      // R6 single-bit sweep, plus an exact hit
      step(1, AW'(3), mem[3], 1'b1, "R6");
      for (int b = 0; b < DW; b++)
        step(1, AW'(b % DEPTH), mem[b % DEPTH] ^ (DW'(1) << b), 1'b1, "R6");
      step(1, AW'(7), mem[7], 1'b1, "R6");
      idle(2);
      // R10 both requests at once
      step(3, AW'(9), mem[9], 1'b1, "R10");
      step(3, AW'(10), ~mem[10], 1'b1, "R10");
      idle(2);
      // R8 back-to-back random stream with R4 or R5 latency
      for (int i = 0; i < 300; i++) begin
        int k;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        k = $urandom_range(0, 3);
        a = AW'($urandom);
        d = $urandom_range(0, 1) ? mem[a] : mem[a] ^ DW'($urandom_range(1, 7));
        step(k, a, d, ($urandom_range(0, 3) != 0),
             ftMode ? "R8 R4" : "R8 R5");
      end
      idle(3);
    end

    // R7 asynchronous gating between edges
    ftMode = 1'b0;
    step(1, AW'(4), mem[4], 1'b1, "R7");
    step(0, '0, '0, 1'b1, "R7");
    @(negedge clk);
    #1;
    chk("R7 valid hit", DW'(matchValid), DW'(1));
    chk("R7 match on", DW'(match), DW'(1));
    matchOutEn = 1'b0;
    #1;
    chk("R7 match off", DW'(match), '0);
    chk("R7 drive off", DW'(matchDrive), '0);
    chk("R7 valid kept", DW'(matchValid), DW'(1));
    matchOutEn = 1'b1;
    #1;
    chk("R7 match back", DW'(match), DW'(1));
    histKind[0] = 0; histKind[1] = 0;
    idle(3);

    // R9 read back every word after all compares
    ftMode = 1'b1;
    idle(2);
    for (int i = 0; i < DEPTH; i++) begin
      step(2, AW'(i), '0, 1'b1, "R9");
      histData[0] = golden[i];
    end
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule